// File: doc/BRIEF.md
# Spare-area buffer address mapper for a NAND page buffer

This block turns a linear byte window inside one NAND page (data area followed by the spare area) into a series of bursts. Each burst is an address in an on-chip page buffer RAM plus a byte count, and a copy engine can carry it out directly. The data area sits in the RAM as one linear region that starts at address 0. The spare area is not linear. It is cut into one slice per 512 data bytes, and each slice lives in its own fixed 64-byte spare buffer. The eight spare buffers start at 0x1000, 0x1040, 0x1080 and so on.

A request gives a start column, a length, a write flag and a spare-only flag. The page geometry comes from a two-bit code. The block keeps a running column pointer and produces one burst per accepted cycle. A request that runs past the end of the data area is split, and the rest continues in the spare buffers. A single `done` pulse follows the last burst.

Top module: `nsm_spare_mapper`

## Requirements
- R1: After reset, `req_ready` is 1, `burst_valid` is 0 and `done` is 0. `burst_valid` and `req_ready` are never high together.
- R2: A column below the page size, with spare-only off, gives a burst whose address equals the column. Its length is the smaller of the remaining request length and (page size minus column).
- R3: When a request crosses the end of the data area, the next burst starts at spare offset 0, address 0x1000, and carries the rest of the request.
- R4: A spare offset s maps to buffer k = s / B and in-buffer offset o = s − k·B. B is (spare size / (page size / 512)) with bit 0 cleared. The burst address is 0x1000 + k·0x40 + o.
- R5: A spare burst is no longer than B − o, the bytes left in its buffer, and no longer than the bytes left in the request. Every burst length is non-zero.
- R6: The buffer index is clamped to 7. In the last buffer, an in-buffer offset of B or more gives a burst that takes the whole rest of the request.
- R7: With spare-only set, a column below the page size is used directly as the spare offset. A column at or above the page size has the page size subtracted in either mode.
- R8: `cur_col` loads the start column when a request is accepted and advances by the length of each accepted burst. After `done` it equals start column plus length.
- R9: A request of length 0 raises `done` in the cycle after it is accepted and issues no burst.
- R10: `done` is a one-cycle pulse in the cycle after the final burst handshake. A burst held with `burst_ready` low keeps its address and length.
- R11: `burst_write` repeats the write flag captured with the request, on every burst of that request.
- R12: The geometry codes are 0 = 512/16, 1 = 2048/64, 2 = 4096/128 and 3 = 4096/218 (data bytes/spare bytes). This gives B = 16, 16, 16 and 26.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| geom | input | 2 | Page geometry code, held stable during a request |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_col | input | 13 | Start column within the page |
| req_len | input | 13 | Request length in bytes |
| req_write | input | 1 | Direction flag passed to the bursts |
| req_spare_only | input | 1 | Treat the column as a spare-area offset |
| burst_valid | output | 1 | Burst descriptor valid |
| burst_ready | input | 1 | Copy engine takes the burst |
| burst_addr | output | 13 | Buffer RAM byte address |
| burst_len | output | 13 | Burst byte count |
| burst_write | output | 1 | Direction of the burst |
| done | output | 1 | One-cycle pulse when the request is finished |
| cur_col | output | 13 | Running column pointer |

## Verification
The properties assume three things about the inputs. `geom` does not change while a request is running. A request never goes past data plus spare bytes for its geometry. The copy engine may stall at any time. Under these assumptions every spare address stays inside the eight spare buffers. The stimulus follows the same rules: each request is fitted to its own geometry, the code changes only while the block is idle, and `burst_ready` is dropped in a repeating pattern so that held bursts occur in mid-request.

// File: rtl/nsm_pkg.sv
package nsm_pkg;

    localparam int COL_W        = 13;
    localparam int CHUNK_BYTES  = 512;
    localparam int SPARE_BUFS   = 8;
    localparam int SPARE_STRIDE = 64;
    localparam int SPARE_BASE   = 4096;

    typedef logic [COL_W-1:0] col_t;

    typedef enum logic [1:0] {
        GEOM_512_16  = 2'd0,
        GEOM_2K_64   = 2'd1,
        GEOM_4K_128  = 2'd2,
        GEOM_4K_218  = 2'd3
    } geom_e;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_e;

    typedef struct packed {
        col_t addr;
        col_t len;
    } burst_t;

    function automatic col_t page_bytes(geom_e g);
        case (g)
            GEOM_512_16: return col_t'(512);
            GEOM_2K_64:  return col_t'(2048);
            default:     return col_t'(4096);
        endcase
    endfunction

    function automatic col_t spare_bytes(geom_e g);
        case (g)
            GEOM_512_16: return col_t'(16);
            GEOM_2K_64:  return col_t'(64);
            GEOM_4K_128: return col_t'(128);
            default:     return col_t'(218);
        endcase
    endfunction

    // usable bytes per spare buffer: even share of the spare area per chunk
    function automatic col_t bytes_per_buf(geom_e g);
        col_t chunks;
        col_t share;
        chunks = page_bytes(g) / col_t'(CHUNK_BYTES);
        share  = spare_bytes(g) / chunks;
        return share & ~col_t'(1);
    endfunction

    function automatic col_t min_col(col_t a, col_t b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/nsm_addr_calc.sv
module nsm_addr_calc
    import nsm_pkg::*;
#(
    parameter int NUM_SPARE = SPARE_BUFS,
    parameter int STRIDE    = SPARE_STRIDE,
    parameter int BASE      = SPARE_BASE
) (
    input  geom_e  geom,
    input  logic   spare_only,
    input  col_t   col,
    input  col_t   rem,
    output burst_t burst
);
    localparam int   IDX_W    = $clog2(NUM_SPARE);
    localparam col_t LAST_IDX = col_t'(NUM_SPARE - 1);

    col_t page;
    col_t per_buf;
    col_t soff;
    col_t idx_raw;
    col_t idx;
    col_t in_off;
    col_t room;
    logic in_spare;

    always_comb begin
        page     = page_bytes(geom);
        per_buf  = bytes_per_buf(geom);
        in_spare = spare_only || (col >= page);
        soff     = (col >= page) ? (col - page) : col;
        idx_raw  = soff / per_buf;
        idx      = (idx_raw > LAST_IDX) ? LAST_IDX : idx_raw;
        in_off   = soff - idx * per_buf;
        // past the nominal share of the last buffer, the buffer takes the rest
        room     = (in_off < per_buf) ? (per_buf - in_off) : rem;
        if (in_spare) begin
            burst.len  = min_col(rem, room);
            burst.addr = col_t'(BASE) + idx * col_t'(STRIDE) + in_off;
        end else begin
            burst.len  = min_col(rem, page - col);
            burst.addr = col;
        end
    end

    logic unused_idx;
    assign unused_idx = ^idx[COL_W-1:IDX_W];

endmodule

// File: rtl/nsm_seq.sv
module nsm_seq
    import nsm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  col_t req_col,
    input  col_t req_len,
    input  logic req_write,
    input  logic req_spare_only,
    input  logic burst_ready,
    input  col_t step_len,
    output logic req_ready,
    output logic burst_valid,
    output col_t col,
    output col_t rem,
    output logic write_q,
    output logic spare_only_q,
    output logic done
);
    seq_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= SEQ_IDLE;
            col          <= '0;
            rem          <= '0;
            write_q      <= 1'b0;
            spare_only_q <= 1'b0;
            done         <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (req_valid) begin
                        col          <= req_col;
                        rem          <= req_len;
                        write_q      <= req_write;
                        spare_only_q <= req_spare_only;
                        if (req_len == '0) begin
                            done <= 1'b1;
                        end else begin
                            state <= SEQ_RUN;
                        end
                    end
                end
                default: begin
                    if (burst_ready) begin
                        col <= col + step_len;
                        rem <= rem - step_len;
                        if (step_len == rem) begin
                            state <= SEQ_IDLE;
                            done  <= 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    assign req_ready   = (state == SEQ_IDLE);
    assign burst_valid = (state == SEQ_RUN);

endmodule

// File: rtl/nsm_spare_mapper.sv
module nsm_spare_mapper
    import nsm_pkg::*;
#(
    parameter int NUM_SPARE = SPARE_BUFS,
    parameter int STRIDE    = SPARE_STRIDE,
    parameter int BASE      = SPARE_BASE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       geom,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [COL_W-1:0] req_col,
    input  logic [COL_W-1:0] req_len,
    input  logic             req_write,
    input  logic             req_spare_only,
    output logic             burst_valid,
    input  logic             burst_ready,
    output logic [COL_W-1:0] burst_addr,
    output logic [COL_W-1:0] burst_len,
    output logic             burst_write,
    output logic             done,
    output logic [COL_W-1:0] cur_col
);
    col_t   col;
    col_t   rem;
    logic   spare_only_q;
    burst_t burst;

    nsm_seq i_seq (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (req_valid),
        .req_col        (req_col),
        .req_len        (req_len),
        .req_write      (req_write),
        .req_spare_only (req_spare_only),
        .burst_ready    (burst_ready),
        .step_len       (burst.len),
        .req_ready      (req_ready),
        .burst_valid    (burst_valid),
        .col            (col),
        .rem            (rem),
        .write_q        (burst_write),
        .spare_only_q   (spare_only_q),
        .done           (done)
    );

    nsm_addr_calc #(
        .NUM_SPARE (NUM_SPARE),
        .STRIDE    (STRIDE),
        .BASE      (BASE)
    ) i_calc (
        .geom       (geom_e'(geom)),
        .spare_only (spare_only_q),
        .col        (col),
        .rem        (rem),
        .burst      (burst)
    );

    assign burst_addr = burst.addr;
    assign burst_len  = burst.len;
    assign cur_col    = col;

endmodule

// File: rtl/nsm_spare_mapper_chk.sv
module nsm_spare_mapper_chk
    import nsm_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_ready,
    input logic             burst_valid,
    input logic             burst_ready,
    input logic [COL_W-1:0] burst_addr,
    input logic [COL_W-1:0] burst_len,
    input logic             done,
    input logic [COL_W-1:0] cur_col
);
    localparam col_t SPARE_END = col_t'(SPARE_BASE + SPARE_BUFS * SPARE_STRIDE);

    p_excl_r1: assert property (@(posedge clk) disable iff (rst)
        !(burst_valid && req_ready));

    p_main_addr_r2: assert property (@(posedge clk) disable iff (rst)
        (burst_valid && burst_addr < col_t'(SPARE_BASE)) |-> burst_addr == cur_col);

    p_spare_range_r4: assert property (@(posedge clk) disable iff (rst)
        (burst_valid && burst_addr >= col_t'(SPARE_BASE)) |-> burst_addr < SPARE_END);

    p_len_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
        burst_valid |-> burst_len != '0);

    p_col_adv_r8: assert property (@(posedge clk) disable iff (rst)
        (burst_valid && burst_ready) |=> cur_col == col_t'($past(cur_col) + $past(burst_len)));

    p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> (req_ready && !burst_valid));

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (burst_valid && !burst_ready) |=>
            (burst_valid && $stable(burst_addr) && $stable(burst_len)));

endmodule

bind nsm_spare_mapper nsm_spare_mapper_chk i_chk (.*);

// File: tb/test_nsm_spare_mapper.sv
module test_nsm_spare_mapper;
    import nsm_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] geom = 2'd0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [12:0] req_col = '0;
    logic [12:0] req_len = '0;
    logic       req_write = 1'b0;
    logic       req_spare_only = 1'b0;
    logic       burst_valid;
    logic       burst_ready = 1'b1;
    logic [12:0] burst_addr;
    logic [12:0] burst_len;
    logic       burst_write;
    logic       done;
    logic [12:0] cur_col;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit finished = 0;

    typedef struct {
        int    addr;
        int    len;
        bit    wr;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    nsm_spare_mapper i_nsm_spare_mapper (.*);

    task automatic check(bit ok, string tag, int act, int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // independent model of the address split
    task automatic model(int g, int col, int len, bit wr, bit so);
        int page, spare, bpb, rem, c, soff, idx, o, av, l, addr;
        string tag;
        bit seen_main;
        page  = (g == 0) ? 512 : (g == 1) ? 2048 : 4096;
        spare = (g == 0) ? 16 : (g == 1) ? 64 : (g == 2) ? 128 : 218;
        bpb   = (spare / (page / 512)) & ~1;
        c = col; rem = len; seen_main = 0;
        while (rem > 0) begin
            if (!so && c < page) begin
                l = (rem < page - c) ? rem : page - c;
                addr = c; tag = "R2"; seen_main = 1;
            end else begin
                soff = (c >= page) ? c - page : c;
                idx  = soff / bpb;
                if (idx > 7) idx = 7;
                o  = soff - idx * bpb;
                av = (o < bpb) ? bpb - o : rem;
                l  = (rem < av) ? rem : av;
                addr = 4096 + idx * 64 + o;
                if (seen_main) tag = "R3";
                else if (so) tag = "R7";
                else if (soff / bpb > 7 || o >= bpb) tag = "R6";
                else tag = "R4_R5";
                seen_main = 0;
            end
            exp_q.push_back('{addr, l, wr, tag});
            c += l; rem -= l;
        end
    endtask

    task automatic run_req(int g, int col, int len, bit wr, bit so);
        model(g, col, len, wr, so);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        geom = 2'(g); req_col = 13'(col); req_len = 13'(len);
        req_write = wr; req_spare_only = so; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        check(exp_q.size() == 0, "R9 all bursts issued", exp_q.size(), 0);
        check(int'(cur_col) == col + len, "R8 final column", int'(cur_col), col + len);
        @(negedge clk);
        check(!done, "R10 done one cycle", int'(done), 0);
    endtask

    // monitor: decide ready, then compare any handshake about to happen
    int   stall_cnt = 0;
    bit   prev_stall = 0;
    int   prev_addr = 0;
    int   prev_len = 0;
    always @(negedge clk) begin
        if (!rst) begin
            stall_cnt++;
            burst_ready = (stall_cnt % 3) != 2;
            if (prev_stall && burst_valid) begin
                check(int'(burst_addr) == prev_addr, "R10 held addr", int'(burst_addr), prev_addr);
                check(int'(burst_len) == prev_len, "R10 held len", int'(burst_len), prev_len);
            end
            prev_stall = burst_valid && !burst_ready;
            prev_addr  = int'(burst_addr);
            prev_len   = int'(burst_len);
            if (burst_valid && burst_ready) begin
                if (exp_q.size() == 0) begin
                    check(0, "R9 unexpected burst", int'(burst_addr), -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(int'(burst_addr) == e.addr, {e.tag, " addr"}, int'(burst_addr), e.addr);
                    check(int'(burst_len) == e.len, {e.tag, " len"}, int'(burst_len), e.len);
                    check(burst_write == e.wr, "R11 write flag", int'(burst_write), int'(e.wr));
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            check(0, "watchdog", cycles, 150000);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        check(burst_valid == 1'b0, "R1 no burst after reset", int'(burst_valid), 0);
        check(done == 1'b0, "R1 no done after reset", int'(done), 0);

        run_req(0, 0, 528, 0, 0);        // R2 then R3 crossing, R12 code 0
        run_req(1, 2040, 20, 1, 0);      // R3 crossing, R11 write
        run_req(1, 2058, 30, 0, 0);      // R4 R5 buffer splits
        run_req(3, 4266, 48, 1, 0);      // R6 clamp into last buffer
        run_req(2, 0, 128, 0, 1);        // R7 spare-only, eight buffers
        run_req(0, 100, 0, 0, 0);        // R9 zero length
        run_req(3, 0, 4314, 1, 0);       // R12 whole page, code 3
        run_req(0, 300, 50, 0, 0);       // R2 main only
        run_req(3, 4096, 218, 0, 0);     // R6 spare sweep 26-byte shares
        run_req(2, 4100, 30, 1, 0);      // R4 R12 code 2
        run_req(3, 200, 12, 0, 1);       // R7 spare-only beyond share

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule